// File: doc/BRIEF.md
# Paged Emulation Memory Overlay Mapper

This block sits between the bus of an emulated 8-bit microcontroller and two memory sources: local replacement RAM inside the emulator and the external memory of the target board. For every access it decides which source serves it. It drives a local-RAM chip select and a target-bus enable, and it multiplexes the read data back to the core. The decision is made independently for each 256-byte page.

The 4K program space is divided into sixteen 256-byte pages, and each page has its own routing bit. The external data space is one 256-byte page with one routing bit of its own. A host write port loads both maps while emulation runs. The local storage is modelled as arrays with synchronous write and combinational read. One array of 4K bytes holds program pages. A second array of 320 bytes holds the 256-byte external data page and the 64 bytes of internal data memory.

Top module: `emu_overlay_map`

## Requirements
- R1: After reset both maps are all zero. A valid program (kind 2'b00) or external data (kind 2'b01) access then has `tgt_en_o` high and `lram_cs_o` low until the host writes a map.
- R2: A program access uses address bits [11:8] as the page index and reads that bit of the program map (1 = local RAM, 0 = target). A host write with `host_sel_i`=0 loads all 16 bits from `host_wdata_i`, and the new value takes effect from the next cycle.
- R3: An external data access uses only the data map bit. A host write with `host_sel_i`=1 loads that bit from `host_wdata_i[0]` and leaves the program map unchanged.
- R4: `lram_cs_o` and `tgt_en_o` are never high together. While `lram_cs_o` is high, `rdata_o` comes from local RAM and `tgt_rdata_i` has no effect on it.
- R5: While `tgt_en_o` is high, `rdata_o` equals `tgt_rdata_i` in the same cycle.
- R6: A write (`acc_we_i`=1) to a locally mapped location updates the array at the clock edge where the strobe is seen, and a read returns the new data from the next cycle. A write to a target-mapped location leaves the local array unchanged.
- R7: An internal data access (kind 2'b10) is always local. It uses only `acc_addr_i[5:0]`, and its storage is separate from the external data page.
- R8: With `acc_valid_i` low or kind 2'b11, both enables are low and `rdata_o` is zero.
- R9: Program storage and external data storage are separate, so a write to program address N does not change external data byte N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host map write strobe |
| host_sel_i | input | 1 | Map selected for the write: 0 program, 1 external data |
| host_wdata_i | input | 16 | Map write value |
| acc_valid_i | input | 1 | Core access valid this cycle |
| acc_kind_i | input | 2 | 00 program, 01 external data, 10 internal data, 11 none |
| acc_addr_i | input | 12 | Access address |
| acc_we_i | input | 1 | Core write strobe |
| acc_wdata_i | input | 8 | Core write data |
| tgt_rdata_i | input | 8 | Read data from the target bus |
| lram_cs_o | output | 1 | Local RAM chip select |
| tgt_en_o | output | 1 | Target bus enable |
| rdata_o | output | 8 | Read data returned to the core |

## Verification
On every cycle the assertions check these rules: the two enables are exclusive, the idle state holds, internal data accesses stay local, and target data passes through. They also check the routing against the host value written on the previous edge, and that accesses stay on the target until the first host write. The bench's scenarios are the only place that shows stored contents. Among them: data written while a page was local survives a period of target mapping, and program, external and internal storage do not alias one another.

// File: rtl/emu_map_pkg.sv
package emu_map_pkg;
  typedef enum logic [1:0] {
    ACC_PROG  = 2'b00,
    ACC_XDATA = 2'b01,
    ACC_IDATA = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/emu_map_regs.sv
module emu_map_regs #(
  parameter int PAGE_CNT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_we_i,
  input  logic                host_sel_i,
  input  logic [PAGE_CNT-1:0] host_wdata_i,
  output logic [PAGE_CNT-1:0] pmap_o,
  output logic                dmap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmap_o <= '0;
      dmap_o <= 1'b0;
    end else if (host_we_i) begin
      if (host_sel_i) dmap_o <= host_wdata_i[0];
      else            pmap_o <= host_wdata_i;
    end
  end
endmodule

// File: rtl/emu_page_decode.sv
module emu_page_decode
  import emu_map_pkg::*;
#(
  parameter int PAGE_CNT = 16,
  localparam int PIDX_W  = $clog2(PAGE_CNT)
) (
  input  logic                acc_valid_i,
  input  acc_kind_e           acc_kind_i,
  input  logic [PIDX_W-1:0]   page_i,
  input  logic [PAGE_CNT-1:0] pmap_i,
  input  logic                dmap_i,
  output logic                cs_prog_o,
  output logic                cs_data_o,
  output logic                tgt_en_o
);
  always_comb begin
    cs_prog_o = 1'b0;
    cs_data_o = 1'b0;
    tgt_en_o  = 1'b0;
    if (acc_valid_i) begin
      unique case (acc_kind_i)
        ACC_PROG: begin
          cs_prog_o = pmap_i[page_i];
          tgt_en_o  = ~pmap_i[page_i];
        end
        ACC_XDATA: begin
          cs_data_o = dmap_i;
          tgt_en_o  = ~dmap_i;
        end
        ACC_IDATA: cs_data_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/emu_local_ram.sv
module emu_local_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/emu_overlay_map.sv
module emu_overlay_map
  import emu_map_pkg::*;
#(
  parameter int PAGE_W      = 8,
  parameter int PAGE_CNT    = 16,
  parameter int IDATA_BYTES = 64,
  parameter int DATA_W      = 8,
  localparam int PIDX_W     = $clog2(PAGE_CNT),
  localparam int ADDR_W     = PAGE_W + PIDX_W,
  localparam int PROG_DEPTH = PAGE_CNT << PAGE_W,
  localparam int DATA_DEPTH = (1 << PAGE_W) + IDATA_BYTES,
  localparam int D_AW       = $clog2(DATA_DEPTH),
  localparam int IDX_W      = $clog2(IDATA_BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_we_i,
  input  logic                host_sel_i,
  input  logic [PAGE_CNT-1:0] host_wdata_i,
  input  logic                acc_valid_i,
  input  logic [1:0]          acc_kind_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic                acc_we_i,
  input  logic [DATA_W-1:0]   acc_wdata_i,
  input  logic [DATA_W-1:0]   tgt_rdata_i,
  output logic                lram_cs_o,
  output logic                tgt_en_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam logic [D_AW-1:0] IDATA_BASE = D_AW'(1 << PAGE_W);

  acc_kind_e             kind;
  logic [PAGE_CNT-1:0]   pmap;
  logic                  dmap;
  logic                  cs_prog, cs_data;
  logic [D_AW-1:0]       data_addr;
  logic [DATA_W-1:0]     prog_rd, data_rd;

  assign kind = acc_kind_e'(acc_kind_i);

  emu_map_regs #(.PAGE_CNT(PAGE_CNT)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (host_we_i),
    .host_sel_i  (host_sel_i),
    .host_wdata_i(host_wdata_i),
    .pmap_o      (pmap),
    .dmap_o      (dmap)
  );

  emu_page_decode #(.PAGE_CNT(PAGE_CNT)) u_dec (
    .acc_valid_i(acc_valid_i),
    .acc_kind_i (kind),
    .page_i     (acc_addr_i[ADDR_W-1:PAGE_W]),
    .pmap_i     (pmap),
    .dmap_i     (dmap),
    .cs_prog_o  (cs_prog),
    .cs_data_o  (cs_data),
    .tgt_en_o   (tgt_en_o)
  );

  // internal data sits above the external page in the data array
  assign data_addr = (kind == ACC_IDATA)
                   ? IDATA_BASE + D_AW'(acc_addr_i[IDX_W-1:0])
                   : D_AW'(acc_addr_i[PAGE_W-1:0]);

  emu_local_ram #(.DEPTH(PROG_DEPTH), .DATA_W(DATA_W)) u_prog_ram (
    .clk_i  (clk_i),
    .we_i   (cs_prog & acc_we_i),
    .addr_i (acc_addr_i),
    .wdata_i(acc_wdata_i),
    .rdata_o(prog_rd)
  );

  emu_local_ram #(.DEPTH(DATA_DEPTH), .DATA_W(DATA_W)) u_data_ram (
    .clk_i  (clk_i),
    .we_i   (cs_data & acc_we_i),
    .addr_i (data_addr),
    .wdata_i(acc_wdata_i),
    .rdata_o(data_rd)
  );

  assign lram_cs_o = cs_prog | cs_data;

  always_comb begin
    if (cs_prog)       rdata_o = prog_rd;
    else if (cs_data)  rdata_o = data_rd;
    else if (tgt_en_o) rdata_o = tgt_rdata_i;
    else               rdata_o = '0;
  end
endmodule

// File: rtl/emu_overlay_map_chk.sv
module emu_overlay_map_chk #(
  parameter int PAGE_W   = 8,
  parameter int PAGE_CNT = 16,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = PAGE_W + $clog2(PAGE_CNT)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                host_we_i,
  input logic                host_sel_i,
  input logic [PAGE_CNT-1:0] host_wdata_i,
  input logic                acc_valid_i,
  input logic [1:0]          acc_kind_i,
  input logic [ADDR_W-1:0]   acc_addr_i,
  input logic [DATA_W-1:0]   tgt_rdata_i,
  input logic                lram_cs_o,
  input logic                tgt_en_o,
  input logic [DATA_W-1:0]   rdata_o
);
  logic                prev_pwr, prev_dwr, loaded;
  logic [PAGE_CNT-1:0] prev_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_pwr   <= 1'b0;
      prev_dwr   <= 1'b0;
      loaded     <= 1'b0;
      prev_wdata <= '0;
    end else begin
      prev_pwr   <= host_we_i & ~host_sel_i;
      prev_dwr   <= host_we_i & host_sel_i;
      prev_wdata <= host_wdata_i;
      if (host_we_i) loaded <= 1'b1;
    end
  end

  // R1
  reset_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loaded && acc_valid_i && !acc_kind_i[1]) |-> (tgt_en_o && !lram_cs_o));

  // R2
  prog_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_pwr && acc_valid_i && acc_kind_i == 2'b00)
      |-> (lram_cs_o == prev_wdata[acc_addr_i[ADDR_W-1:PAGE_W]]));

  // R3
  data_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_dwr && acc_valid_i && acc_kind_i == 2'b01) |-> (lram_cs_o == prev_wdata[0]));

  // R4
  excl_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lram_cs_o && tgt_en_o));

  // R5
  tgt_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_en_o |-> (rdata_o == tgt_rdata_i));

  // R7
  idata_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_kind_i == 2'b10) |-> (lram_cs_o && !tgt_en_o));

  // R8
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i || acc_kind_i == 2'b11) |-> (!lram_cs_o && !tgt_en_o && rdata_o == '0));
endmodule

bind emu_overlay_map emu_overlay_map_chk #(
  .PAGE_W  (PAGE_W),
  .PAGE_CNT(PAGE_CNT),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/emu_overlay_map_test.sv
module emu_overlay_map_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we_i = 1'b0, host_sel_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic        acc_valid_i = 1'b0, acc_we_i = 1'b0;
  logic [1:0]  acc_kind_i = 2'b11;
  logic [11:0] acc_addr_i = '0;
  logic [7:0]  acc_wdata_i = '0, tgt_rdata_i = '0;
  logic        lram_cs_o, tgt_en_o;
  logic [7:0]  rdata_o;

  int vectors = 0, miscompares = 0;
  bit [7:0] prog_m [4096];
  bit       prog_k [4096];
  bit [7:0] data_m [320];
  bit       data_k [320];
  bit [15:0] pmap_m = '0;
  bit        dmap_m = 1'b0;

  always #5 clk_i = ~clk_i;

  emu_overlay_map uut (.*);

  task automatic acc(bit v, bit [1:0] k, int a, bit we = 0, bit [7:0] wd = 0, bit [7:0] td = 0);
    acc_valid_i = v; acc_kind_i = k; acc_addr_i = 12'(a);
    acc_we_i = we; acc_wdata_i = wd; tgt_rdata_i = td;
  endtask

  task automatic host(bit we, bit sel = 0, bit [15:0] d = 0);
    host_we_i = we; host_sel_i = sel; host_wdata_i = d;
  endtask

  // reference: outputs from the current model state, then model update at the edge
  task automatic step(string tag);
    bit loc, tgt, is_prog, known;
    int idx;
    bit [7:0] exp_rd;
    loc = 0; tgt = 0; is_prog = 0; idx = 0; known = 1; exp_rd = 0;
    @(negedge clk_i);
    if (acc_valid_i) begin
      case (acc_kind_i)
        2'b00: begin loc = pmap_m[acc_addr_i[11:8]]; tgt = !loc; is_prog = 1; idx = int'(acc_addr_i); end
        2'b01: begin loc = dmap_m; tgt = !loc; idx = int'(acc_addr_i[7:0]); end
        2'b10: begin loc = 1; idx = 256 + int'(acc_addr_i[5:0]); end
        default: ;
      endcase
    end
    if (loc) begin
      exp_rd = is_prog ? prog_m[idx] : data_m[idx];
      known  = is_prog ? prog_k[idx] : data_k[idx];
    end else if (tgt) exp_rd = tgt_rdata_i;
    vectors++;
    if (lram_cs_o !== loc || tgt_en_o !== tgt || (known && rdata_o !== exp_rd)) begin
      miscompares++;
      $display("FAIL %s: cs/tgt/rdata got %b/%b/%h expected %b/%b/%h", tag,
               lram_cs_o, tgt_en_o, rdata_o, loc, tgt, exp_rd);
    end
    @(posedge clk_i);
    if (rst_ni) begin
      if (loc && acc_we_i) begin
        if (is_prog) begin prog_m[idx] = acc_wdata_i; prog_k[idx] = 1; end
        else         begin data_m[idx] = acc_wdata_i; data_k[idx] = 1; end
      end
      if (host_we_i) begin
        if (host_sel_i) dmap_m = host_wdata_i[0];
        else            pmap_m = host_wdata_i;
      end
    end
    #1;
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R8 idle during reset
    acc(0, 2'b00, 0); step("R8");
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // R1 reset maps: everything on target, R5 passthrough
    acc(1, 2'b00, 'h123, 0, 0, 8'h5A); step("R1");
    acc(1, 2'b01, 'h0F0, 0, 0, 8'hC3); step("R1");
    acc(1, 2'b00, 'hFFF, 0, 0, 8'h00); step("R5");
    acc(1, 2'b00, 'h800, 0, 0, 8'hFF); step("R5");
    acc(1, 2'b11, 'h321, 0, 0, 8'hEE); step("R8");

    // R2 program map load, takes effect next cycle
    host(1, 0, 16'hA5C3); acc(1, 2'b00, 'h000, 0, 0, 8'h11); step("R2");
    host(0);
    for (int p = 0; p < 16; p++) begin
      acc(1, 2'b00, (p << 8) | 'h42, 1, 8'(p * 7 + 1), 8'h99); step("R6");
    end
    for (int p = 0; p < 16; p++) begin
      acc(1, 2'b00, (p << 8) | 'h42, 0, 0, 8'(8'hF0 ^ p)); step("R2");
    end

    // R4: tgt_rdata ignored while local
    acc(1, 2'b00, 'h042, 0, 0, 8'hAA); step("R4");
    acc(1, 2'b00, 'h042, 0, 0, 8'h55); step("R4");

    // R6: target write leaves local content
    acc(1, 2'b00, 'h300, 1, 8'h11); step("R6");         // page 3 local in A5C3? bit3=0 -> target
    host(1, 0, 16'hFFFF); acc(0, 2'b11, 0); step("R6");
    host(0); acc(1, 2'b00, 'h300, 1, 8'h11); step("R6");
    host(1, 0, 16'h0000); acc(0, 2'b11, 0); step("R6");
    host(0); acc(1, 2'b00, 'h300, 1, 8'h22, 8'h77); step("R6");
    host(1, 0, 16'h0008); acc(0, 2'b11, 0); step("R6");
    host(0); acc(1, 2'b00, 'h300, 0, 0, 8'h77); step("R6");

    // R3: data map independent of program map
    host(1, 1, 16'h0001); acc(1, 2'b01, 'h010, 0, 0, 8'h3C); step("R3");
    host(0); acc(1, 2'b01, 'h010, 1, 8'hB7); step("R3");
    acc(1, 2'b01, 'h010, 0, 0, 8'h3C); step("R3");
    acc(1, 2'b00, 'h000, 0, 0, 8'h4D); step("R3");      // page 0 still target

    // R9: program write to 0x010 does not touch external byte 0x10
    host(1, 0, 16'h0001); acc(0, 2'b11, 0); step("R9");
    host(0); acc(1, 2'b00, 'h010, 1, 8'h6E); step("R9");
    acc(1, 2'b01, 'h010); step("R9");
    acc(1, 2'b00, 'h010); step("R9");

    // R7: internal data always local, addr[5:0], separate from external page
    acc(1, 2'b10, 'hFC5, 1, 8'hD1); step("R7");
    acc(1, 2'b01, 'h005, 1, 8'h2E); step("R7");
    acc(1, 2'b10, 'h005, 0, 0, 8'h99); step("R7");
    acc(1, 2'b01, 'h005); step("R7");
    host(1, 1, 16'h0000); acc(1, 2'b10, 'h045, 0, 0, 8'h13); step("R7");
    host(0); acc(1, 2'b10, 'h005, 0, 0, 8'h13); step("R7");
    acc(1, 2'b01, 'h005, 0, 0, 8'h13); step("R5");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 15) == 0) host(1, 1'($urandom), 16'($urandom));
      else host(0);
      acc(1'($urandom_range(0, 7) != 0), 2'($urandom), int'($urandom_range(0, 4095)),
          1'($urandom), 8'($urandom), 8'($urandom));
      step("R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule